// File: doc/BRIEF.md
# Chained Interrupt Aggregator

This block collects a set of peripheral interrupt lines (32 by default) and presents them to a parent interrupt controller as one interrupt output. Each source line first passes through a two-flop synchroniser. It then sets a sticky pending bit, and that bit stays set until software clears it. The output is raised while any pending source is also enabled.

Software uses a small 32-bit register port with single-cycle write strobes and one-cycle read latency. Three registers sit on this port:

- A disable register: a 1 disables the source. Its reset value has every bit set.
- A software-held clear register: while a bit is 1, the matching pending bit is forced low.
- A read-only status register: it returns pending AND NOT disabled.

To service the output, a handler scans status from the lowest set bit upward. For each source it sets the clear bit and then writes it back to zero. Sources are level interrupts. A source that is still asserted when its clear bit is released therefore becomes pending again.

Top module: `irq_gather`

## Requirements
- R1: After reset the disable register (offset 0x14) reads 0xFFFFFFFF, the clear register (offset 0x10) reads 0, status (offset 0x1C) reads 0, and irq_o is 0.
- R2: A write to offset 0x14 sets the disable register, and a read of 0x14 returns exactly the last value written. Bit i of every register belongs to source i.
- R3: A write to offset 0x10 sets the clear register, and a read of 0x10 returns exactly the last value written.
- R4: A source held high sets its pending bit. Reading 0x1C returns pending AND NOT disable, with source i at bit i.
- R5: A pending bit stays set after its source goes low, until its clear bit is set.
- R6: While clear bit i is 1, pending bit i reads 0 and cannot be set, even with source i high. Clear wins over a new assertion in the same cycle.
- R7: When clear bit i returns to 0 while source i is still high, pending bit i sets again.
- R8: irq_o is a registered OR of the status value. It rises or falls within three clock cycles of the status change and is 0 when every pending source is disabled.
- R9: A disabled source still captures its pending bit, which appears in status once the source is enabled.
- R10: Writes to any offset other than 0x10 and 0x14 change no register, including writes to status. Reads from offsets other than 0x10, 0x14 and 0x1C return 0.
- R11: Every read strobe produces rvalid_o with the data exactly one cycle later. rvalid_o is 0 in a cycle that follows no read.
- R12: A source pulse lasting one clock cycle is captured as pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Asynchronous interrupt source lines |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| irq_o | output | 1 | Aggregated interrupt to the parent controller |

## Verification
The bench builds the block with its defaults: 32 sources, an 8-bit offset and two synchroniser stages. With these values the top source (bit 31) and the low bits can both be reached, so the bit mapping is exercised at both ends of the word. The full three-register map can also be decoded alongside unmapped offsets such as 0x18. Two synchroniser stages keep the capture delay short enough to pin down the irq_o latency and the one-cycle pulse case.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
  localparam int unsigned OFS_CLR = 32'h10;
  localparam int unsigned OFS_DIS = 32'h14;
  localparam int unsigned OFS_STS = 32'h1C;
endpackage

// File: rtl/irq_gather_sync.sv
module irq_gather_sync #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] async_i,
  output logic [N_SRC-1:0] sync_o
);
  logic [STAGES-1:0][N_SRC-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= async_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_gather_pend.sv
module irq_gather_pend #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] sync_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] pend_q;

  // clear dominates a same-cycle assertion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else pend_q <= (pend_q | sync_i) & ~clr_i;
  end

  assign pend_o = pend_q;

  AST_CLR_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((pend_q & $past(clr_i)) == '0)); // R6

  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(pend_q) & ~pend_q & ~$past(clr_i)) == '0)); // R5
endmodule

// File: rtl/irq_gather_regs.sv
module irq_gather_regs
  import irq_gather_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_SRC-1:0]  status_i,
  output logic [N_SRC-1:0]  clr_o,
  output logic [N_SRC-1:0]  dis_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_DIS = ADDR_W'(OFS_DIS);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);

  logic [N_SRC-1:0]  clr_q, dis_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic              rvalid_q;
  logic              hit_clr, hit_dis, hit_sts;

  assign hit_clr = (addr_i == A_CLR);
  assign hit_dis = (addr_i == A_DIS);
  assign hit_sts = (addr_i == A_STS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_q <= '0;
      dis_q <= '1;
    end else if (wr_en_i) begin
      if (hit_clr) clr_q <= wdata_i[N_SRC-1:0];
      if (hit_dis) dis_q <= wdata_i[N_SRC-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_clr)      rd_mux = DATA_W'(clr_q);
    else if (hit_dis) rd_mux = DATA_W'(dis_q);
    else if (hit_sts) rd_mux = DATA_W'(status_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en_i;
      if (rd_en_i) rdata_q <= rd_mux;
    end
  end

  assign clr_o    = clr_q;
  assign dis_o    = dis_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  AST_RVALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o); // R11

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !hit_clr && !hit_dis && !hit_sts) |=> (rdata_o == '0)); // R10

  AST_WR_OTHER_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hit_clr && !hit_dis) |=> ($stable(clr_q) && $stable(dis_q))); // R10
endmodule

// File: rtl/irq_gather.sv
module irq_gather #(
  parameter int unsigned N_SRC       = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              irq_o
);
  logic [N_SRC-1:0] src_sync, pend, clr, dis, status;
  logic             irq_q;

  irq_gather_sync #(.N_SRC(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(src_i), .sync_o(src_sync)
  );

  irq_gather_pend #(.N_SRC(N_SRC)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(src_sync), .clr_i(clr), .pend_o(pend)
  );

  irq_gather_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .status_i(status),
    .clr_o(clr), .dis_o(dis), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  assign status = pend & ~dis;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else irq_q <= |status;
  end

  assign irq_o = irq_q;

  AST_IRQ_RISE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(pend & ~dis) != '0)); // R8

  AST_IRQ_DIS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(dis) == '1) |-> !irq_o); // R8
endmodule

// File: tb/tb_irq_gather.sv
module tb_irq_gather;
  localparam int unsigned N = 32;
  localparam logic [7:0] A_CLR = 8'h10, A_DIS = 8'h14, A_STS = 8'h1C;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  irq_gather dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .irq_o(irq)
  );

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R11: unexpected rvalid, actual %h expected none", rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s: read actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq_o actual %b expected %b", t, irq, e);
    end
  endtask

  localparam logic [31:0] B0 = 32'h1, B5 = 32'h20, B17 = 32'h2_0000, B31 = 32'h8000_0000;

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(A_DIS, 32'hFFFF_FFFF, "R1");
    rd(A_CLR, 32'h0, "R1");
    rd(A_STS, 32'h0, "R1");

    // R9 sources pending while disabled
    src = B0 | B5 | B31;
    idle(5);
    rd(A_STS, 32'h0, "R9");
    chk_irq(1'b0, "R8");

    // R2/R4 enable bits 0 and 5
    wr(A_DIS, ~(B0 | B5));
    rd(A_DIS, ~(B0 | B5), "R2");
    rd(A_STS, B0 | B5, "R4");
    idle(2);
    chk_irq(1'b1, "R8");

    // R5 sticky after source drops
    src = '0;
    idle(5);
    rd(A_STS, B0 | B5, "R5");

    // R3/R6 clear bit 0 held
    wr(A_CLR, B0);
    rd(A_CLR, B0, "R3");
    rd(A_STS, B5, "R6");
    src = B0;
    idle(5);
    rd(A_STS, B5, "R6");

    // R7 release clear with source still high
    wr(A_CLR, 32'h0);
    idle(4);
    rd(A_STS, B0 | B5, "R7");
    src = '0;
    wr(A_CLR, B0);
    wr(A_CLR, 32'h0);
    rd(A_STS, B5, "R6");

    // R9 enable all: bit31 captured earlier while disabled
    wr(A_DIS, 32'h0);
    rd(A_STS, B5 | B31, "R9");

    // R8 clear all, output falls
    wr(A_CLR, 32'hFFFF_FFFF);
    wr(A_CLR, 32'h0);
    rd(A_STS, 32'h0, "R6");
    idle(2);
    chk_irq(1'b0, "R8");

    // R12 one-cycle pulse
    @(negedge clk); src = B17;
    @(negedge clk); src = '0;
    idle(5);
    rd(A_STS, B17, "R12");
    chk_irq(1'b1, "R8");

    // R10 unmapped and read-only offsets
    wr(8'h18, 32'hFFFF_FFFF);
    wr(A_STS, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h18, 32'h0, "R10");
    rd(8'h04, 32'h0, "R10");
    rd(A_DIS, 32'h0, "R10");
    rd(A_CLR, 32'h0, "R10");
    rd(A_STS, B17, "R10");

    // R11 latency and idle rvalid
    @(negedge clk); rd_en = 1'b1; addr = A_DIS;
    exp_q.push_back(32'h0); tag_q.push_back("R11");
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk);
    checks++;
    if (rvalid !== 1'b0) begin
      fails++;
      $display("FAIL R11: rvalid_o actual %b expected 0", rvalid);
    end
    idle(2);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R11: missing reads actual %0d expected 0", exp_q.size());
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule